// File: doc/BRIEF.md
# Dual-Clock BCD Up/Down Counter

A single decimal digit held in 8421 code. Two separate count inputs move the digit. A rising edge on the up input adds one, and a rising edge on the down input takes one away. Both count inputs are ordinary signals that the block samples with its own system clock. Each one passes through a synchronizer chain, and an edge detector then turns each rising edge into a one-cycle count event.

An active-high clear input forces the digit to zero. An active-low load input copies a 4-bit preset bus into the digit. Two active-low terminal outputs, carry and borrow, follow the low phase of the matching count input when the digit sits at its end value. A following stage can therefore use them directly as its own count inputs.

The digit wraps at both ends of the decimal range. A loaded code above nine finds its way back into the range within two up counts.

Top module: `bcd_updown_counter`

## Requirements
- R1: While `clear_i` is high, `count_o` is 0, independent of the clock. Clear takes priority over load and over counting.
- R2: With `clear_i` low and `load_n_i` high, a rising edge on `cnt_up_i` alone adds one to the digit. The new value appears at the third rising clock edge after the input is first sampled high, and 9 goes to 0.
- R3: Under the same conditions, a rising edge on `cnt_dn_i` alone subtracts one, with the same latency, and 0 goes to 9.
- R4: While `load_n_i` is low and `clear_i` is low, the digit takes the value of `preset_i` at each clock edge. Count edges that occur during the load are not counted.
- R5: `carry_n_o` is low exactly when the digit is 9 and `cnt_up_i` is low. Otherwise it is high.
- R6: `borrow_n_o` is low exactly when the digit is 0 and `cnt_dn_i` is low. Otherwise it is high.
- R7: Without a rising edge on either count input the digit holds its value. A falling edge on a count input never changes it.
- R8: Rising edges on both count inputs in the same clock cycle leave the digit unchanged.
- R9: Counting up from a code above 9 follows this mapping: 10→11, 11→6, 12→13, 13→4, 14→15, 15→2.
- R10: Counting down from a code above 9 subtracts one (10→9, 15→14).
- R11: A count input that is low during a clear or a load, and stays low afterwards, has its next rising edge counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples everything |
| clear_i | input | 1 | Asynchronous clear, active high |
| load_n_i | input | 1 | Preset load, active low |
| preset_i | input | 4 | Value copied in during a load |
| cnt_up_i | input | 1 | Up count input, counts on its rising edge |
| cnt_dn_i | input | 1 | Down count input, counts on its rising edge |
| count_o | output | 4 | Current digit, 8421 code |
| carry_n_o | output | 1 | Terminal count up, active low |
| borrow_n_o | output | 1 | Terminal count down, active low |

## Verification
The hardest states to reach are the six codes above nine, because ordinary counting never produces them. The bench reaches every one of the sixteen codes through the load path and then applies a single up or down edge. It compares the result with the wrap rules, computed arithmetically. The carry and borrow outputs are swept over all sixteen codes and all four count-input levels while the load is held low, which keeps the digit fixed during each check. Count inputs held low across a clear or a load are then released to show that their next rising edge is counted.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;

  // next value on an up count; codes above nine drift back into range
  function automatic digit_t bcd_up(input digit_t v);
    case (v)
      4'd9:    bcd_up = 4'd0;
      4'd11:   bcd_up = 4'd6;
      4'd13:   bcd_up = 4'd4;
      4'd15:   bcd_up = 4'd2;
      default: bcd_up = v + 4'd1;
    endcase
  endfunction

  // next value on a down count; only zero wraps
  function automatic digit_t bcd_down(input digit_t v);
    bcd_down = (v == 4'd0) ? 4'd9 : v - 4'd1;
  endfunction
endpackage

// File: rtl/cnt_edge_sync.sv
module cnt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clear_i,
  input  logic din_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // cleared to ones: a high input gives no false edge, a low one gives a real edge later
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or posedge clear_i)
        if (clear_i) chain_q <= '1;
        else         chain_q <= din_i;
    end else begin : g_many
      always_ff @(posedge clk or posedge clear_i)
        if (clear_i) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], din_i};
    end
  endgenerate

  always_ff @(posedge clk or posedge clear_i)
    if (clear_i) prev_q <= 1'b1;
    else         prev_q <= chain_q[STAGES-1];

  assign rise_o = chain_q[STAGES-1] & ~prev_q;

  // a count event lasts exactly one cycle (R7)
  p_single_event_r7: assert property (@(posedge clk) disable iff (clear_i)
    rise_o |=> !rise_o);
endmodule

// File: rtl/bcd_count_core.sv
module bcd_count_core
  import bcd_cnt_pkg::*;
(
  input  logic   clk,
  input  logic   clear_i,
  input  logic   load_n_i,
  input  digit_t preset_i,
  input  logic   up_ev_i,
  input  logic   dn_ev_i,
  output digit_t count_o
);
  digit_t cnt_q;
  logic   do_up, do_dn;

  assign do_up = up_ev_i & ~dn_ev_i;
  assign do_dn = dn_ev_i & ~up_ev_i;

  always_ff @(posedge clk or posedge clear_i)
    if (clear_i)        cnt_q <= '0;
    else if (!load_n_i) cnt_q <= preset_i;
    else if (do_up)     cnt_q <= bcd_up(cnt_q);
    else if (do_dn)     cnt_q <= bcd_down(cnt_q);

  assign count_o = cnt_q;

  p_load_r4: assert property (@(posedge clk) disable iff (clear_i)
    !load_n_i |=> count_o == $past(preset_i));
  p_up_step_r2: assert property (@(posedge clk) disable iff (clear_i)
    (load_n_i && up_ev_i && !dn_ev_i) |=> count_o == bcd_up($past(count_o)));
  p_dn_step_r3: assert property (@(posedge clk) disable iff (clear_i)
    (load_n_i && dn_ev_i && !up_ev_i) |=> count_o == bcd_down($past(count_o)));
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (clear_i)
    (load_n_i && !up_ev_i && !dn_ev_i) |=> $stable(count_o));
  p_both_hold_r8: assert property (@(posedge clk) disable iff (clear_i)
    (load_n_i && up_ev_i && dn_ev_i) |=> $stable(count_o));
  p_stay_valid_r9: assert property (@(posedge clk) disable iff (clear_i)
    (load_n_i && count_o <= 4'd9) |=> count_o <= 4'd9);
endmodule

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter
  import bcd_cnt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       clear_i,
  input  logic       load_n_i,
  input  logic [3:0] preset_i,
  input  logic       cnt_up_i,
  input  logic       cnt_dn_i,
  output logic [3:0] count_o,
  output logic       carry_n_o,
  output logic       borrow_n_o
);
  logic   up_ev, dn_ev;
  digit_t digit;

  cnt_edge_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
    .clk(clk), .clear_i(clear_i), .din_i(cnt_up_i), .rise_o(up_ev));
  cnt_edge_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
    .clk(clk), .clear_i(clear_i), .din_i(cnt_dn_i), .rise_o(dn_ev));

  bcd_count_core u_core (
    .clk(clk), .clear_i(clear_i), .load_n_i(load_n_i), .preset_i(preset_i),
    .up_ev_i(up_ev), .dn_ev_i(dn_ev), .count_o(digit));

  assign count_o    = digit;
  // terminal outputs follow the raw input's low phase so a next stage can count on them
  assign carry_n_o  = ~((digit == 4'd9) & ~cnt_up_i);
  assign borrow_n_o = ~((digit == 4'd0) & ~cnt_dn_i);

  p_carry_at_nine_r5: assert property (@(posedge clk) disable iff (clear_i)
    !carry_n_o |-> (count_o == 4'd9 && !cnt_up_i));
  p_borrow_at_zero_r6: assert property (@(posedge clk) disable iff (clear_i)
    !borrow_n_o |-> (count_o == 4'd0 && !cnt_dn_i));
  p_carry_idle_high_r5: assert property (@(posedge clk) disable iff (clear_i)
    cnt_up_i |-> carry_n_o);
endmodule

// File: tb/bcd_updown_counter_tb.sv
module bcd_updown_counter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       clear_i = 1'b1;
  logic       load_n_i = 1'b1;
  logic [3:0] preset_i = 4'd0;
  logic       cnt_up_i = 1'b1;
  logic       cnt_dn_i = 1'b1;
  logic [3:0] count_o;
  logic       carry_n_o, borrow_n_o;

  int checks = 0;
  int errors = 0;

  bcd_updown_counter dut_i (
    .clk(clk), .clear_i(clear_i), .load_n_i(load_n_i), .preset_i(preset_i),
    .cnt_up_i(cnt_up_i), .cnt_dn_i(cnt_dn_i), .count_o(count_o),
    .carry_n_o(carry_n_o), .borrow_n_o(borrow_n_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_up(input int v);
    if (v < 9) return v + 1;
    if (v == 9) return 0;
    if (v % 2 == 0) return v + 1;
    return 17 - v;
  endfunction

  function automatic int exp_dn(input int v);
    return (v == 0) ? 9 : v - 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input int v);
    preset_i = v[3:0];
    load_n_i = 1'b0;
    tick(2);
    load_n_i = 1'b1;
    tick(1);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    tick(3);
    chk("R1 reset state", count_o, 0);
    clear_i = 1'b0;
    tick(2);

    // R1: clear acts at once and overrides load
    load(7);
    load_n_i = 1'b0;
    #1 clear_i = 1'b1;
    #1 chk("R1 async clear", count_o, 0);
    tick(2);
    chk("R1 clear over load", count_o, 0);
    clear_i = 1'b0;
    load_n_i = 1'b1;
    tick(2);

    // R2/R9 and R7: every code, one up edge; the falling edge alone must not count
    for (int v = 0; v < 16; v++) begin
      load(v);
      cnt_up_i = 1'b0;
      tick(4);
      chk("R7 falling edge holds", count_o, v);
      cnt_up_i = 1'b1;
      tick(4);
      chk((v > 9) ? "R9 up from invalid" : "R2 up step", count_o, exp_up(v));
    end

    // R3/R10: every code, one down edge
    for (int v = 0; v < 16; v++) begin
      load(v);
      cnt_dn_i = 1'b0;
      tick(4);
      cnt_dn_i = 1'b1;
      tick(4);
      chk((v > 9) ? "R10 down from invalid" : "R3 down step", count_o, exp_dn(v));
    end

    // R2: a run of up counts across the wrap
    begin
      int m = 7;
      load(m);
      for (int k = 0; k < 5; k++) begin
        cnt_up_i = 1'b0; tick(3);
        cnt_up_i = 1'b1; tick(4);
        m = exp_up(m);
        chk("R2 up run", count_o, m);
      end
    end

    // R5/R6: terminal outputs over every code and every input level; load held low
    for (int v = 0; v < 16; v++) begin
      for (int u = 0; u < 2; u++) begin
        for (int d = 0; d < 2; d++) begin
          preset_i = v[3:0];
          load_n_i = 1'b0;
          cnt_up_i = u[0];
          cnt_dn_i = d[0];
          tick(2);
          chk("R5 carry", carry_n_o, (v == 9 && u == 0) ? 0 : 1);
          chk("R6 borrow", borrow_n_o, (v == 0 && d == 0) ? 0 : 1);
          cnt_up_i = 1'b1;
          cnt_dn_i = 1'b1;
          tick(4);
          load_n_i = 1'b1;
          tick(1);
        end
      end
    end

    // R4: edges during a load are not counted
    preset_i = 4'd5;
    load_n_i = 1'b0;
    cnt_up_i = 1'b0; tick(3);
    cnt_up_i = 1'b1; tick(5);
    load_n_i = 1'b1;
    tick(4);
    chk("R4 edge during load ignored", count_o, 5);

    // R8: both count inputs rise together
    load(4);
    cnt_up_i = 1'b0; cnt_dn_i = 1'b0; tick(4);
    cnt_up_i = 1'b1; cnt_dn_i = 1'b1; tick(4);
    chk("R8 simultaneous edges", count_o, 4);

    // R11: input low across a clear, then released
    load(3);
    cnt_up_i = 1'b0;
    clear_i = 1'b1; tick(2);
    clear_i = 1'b0; tick(3);
    chk("R11 clear with input low", count_o, 0);
    cnt_up_i = 1'b1; tick(4);
    chk("R11 edge after clear counted", count_o, 1);

    // R11: input low across a load, then released
    cnt_dn_i = 1'b0;
    load(6);
    tick(2);
    chk("R11 load with input low", count_o, 6);
    cnt_dn_i = 1'b1; tick(4);
    chk("R11 edge after load counted", count_o, 5);

    summary();
  end
endmodule